// File: doc/BRIEF.md
# Exception Return-Address and Cause Capture

This block keeps the state a processor needs when an instruction traps. It holds two 32-bit registers: one saves the return address of the faulting instruction, the other records why the trap happened. Each register loads only on its own write strobe, so the control sequencer can update them in whichever cycle suits it.

The block also produces the address the program counter jumps to when it enters the handler. Two dispatch styles are available, picked by a mode input. In common-entry mode every trap goes to one fixed address, and software reads the cause register to learn the reason. In vectored mode the cause itself selects the entry: each cause has its own slot, and the slots are 32 bytes (eight instructions) apart. The handler address is combinational from the current cause select, so it can be loaded into the program counter in the same cycle that the two registers are written.

Top module: `exc_capture`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, and right after it is released, both epc_out and cause_out read 0.
- R2: When epc_we is high at a rising clock edge, epc_out becomes pc_in minus 4, modulo 2^32 (pc_in 0 gives 0xFFFF_FFFC), from that edge on.
- R3: When epc_we is low at a rising clock edge, epc_out keeps its value.
- R4: When cause_we is high at a rising clock edge, cause_out becomes the cause code in bits [6:2] with every other bit 0. cause_sel 0 (undefined instruction) gives code 0 (cause_out 0x0000_0000). cause_sel 1 (arithmetic overflow) gives code 1 (cause_out 0x0000_0004).
- R5: When cause_we is low at a rising clock edge, cause_out keeps its value.
- R6: With vec_mode 0, handler_addr is 0x8000_0180 for either value of cause_sel.
- R7: With vec_mode 1, handler_addr is 0xC000_0000 for cause_sel 0 and 0xC000_0020 for cause_sel 1. It follows the inputs in the same cycle, with no clock edge in between.
- R8: The two strobes are independent. Writing one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| epc_we | input | 1 | Load the return-address register |
| cause_we | input | 1 | Load the cause register |
| cause_sel | input | 1 | Trap reason: 0 undefined instruction, 1 arithmetic overflow |
| pc_in | input | 32 | Current (already incremented) program counter |
| vec_mode | input | 1 | 0 selects the common entry, 1 selects per-cause vectors |
| epc_out | output | 32 | Saved return address |
| cause_out | output | 32 | Saved cause word |
| handler_addr | output | 32 | Handler entry address |

## Verification
Both registers drive the ports directly, so a wrong load or a missed hold shows on epc_out or cause_out at the first falling edge after the clock edge in question. An off-by-one in the return-address arithmetic appears at once, and so does its wraparound at a program counter of zero. A misplaced cause field appears as a bit outside [6:2], or as a code in the wrong position. A wrong dispatch shows on handler_addr within the same cycle that the mode or cause input changes, with no clock edge involved.

// File: rtl/exc_capture.sv
module exc_capture #(
  parameter int          DATA_W       = 32,
  parameter int          CAUSE_CNT    = 2,
  parameter int          CODE_LSB     = 2,
  parameter int          CODE_W       = 5,
  parameter int          SLOT_SHIFT   = 5,
  parameter int          PC_STEP      = 4,
  parameter logic [31:0] COMMON_ENTRY = 32'h8000_0180,
  parameter logic [31:0] VEC_BASE     = 32'hC000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              epc_we,
  input  logic              cause_we,
  input  logic              cause_sel,
  input  logic [DATA_W-1:0] pc_in,
  input  logic              vec_mode,
  output logic [DATA_W-1:0] epc_out,
  output logic [DATA_W-1:0] cause_out,
  output logic [DATA_W-1:0] handler_addr
);

  localparam int SEL_W = (CAUSE_CNT > 1) ? $clog2(CAUSE_CNT) : 1;
  localparam logic [DATA_W-1:0] FIELD_MASK =
    {{(DATA_W-CODE_W){1'b0}}, {CODE_W{1'b1}}} << CODE_LSB;

  logic [DATA_W-1:0] epc_q, cause_q;
  logic [DATA_W-1:0] sel_wide;

  assign sel_wide = {{(DATA_W-SEL_W){1'b0}}, cause_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else begin
      if (epc_we)   epc_q   <= pc_in - DATA_W'(PC_STEP);
      if (cause_we) cause_q <= (sel_wide << CODE_LSB) & FIELD_MASK;
    end
  end

  assign epc_out      = epc_q;
  assign cause_out    = cause_q;
  assign handler_addr = vec_mode ? (DATA_W'(VEC_BASE) + (sel_wide << SLOT_SHIFT))
                                 : DATA_W'(COMMON_ENTRY);

  a_r2_epc_load: assert property (@(posedge clk) disable iff (!rst_n)
    epc_we |=> epc_out == $past(pc_in) - DATA_W'(PC_STEP));

  a_r3_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !epc_we |=> $stable(epc_out));

  a_r4_cause_load: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we |=> cause_out[CODE_LSB +: CODE_W] == CODE_W'($past(cause_sel)));

  a_r4_cause_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_out & ~FIELD_MASK) == '0);

  a_r5_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_we |=> $stable(cause_out));

  a_r6_common_entry: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_mode |-> handler_addr == DATA_W'(COMMON_ENTRY));

  a_r7_vector_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_mode && cause_sel) |-> handler_addr - DATA_W'(VEC_BASE) == DATA_W'(1 << SLOT_SHIFT));

endmodule

// File: tb/exc_capture_bench.sv
module exc_capture_bench;
  localparam int PERIOD = 10;
  localparam int NROW = 8;

  // row: pc[131:100] sel[99] vmode[98] epc_we[97] cause_we[96] handler[95:64] pad[63:0]
  localparam logic [131:0] ROWS [NROW] = '{
    {32'h0040_0004, 1'b0, 1'b0, 1'b1, 1'b1, 32'h8000_0180, 64'd0},
    {32'h0040_0010, 1'b1, 1'b1, 1'b1, 1'b1, 32'hC000_0020, 64'd0},
    {32'h1234_5678, 1'b0, 1'b1, 1'b0, 1'b0, 32'hC000_0000, 64'd0},
    {32'hDEAD_BEEF, 1'b1, 1'b0, 1'b1, 1'b0, 32'h8000_0180, 64'd0},
    {32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 32'hC000_0000, 64'd0},
    {32'h0000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 32'hC000_0020, 64'd0},
    {32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b1, 32'h8000_0180, 64'd0},
    {32'h0000_0004, 1'b0, 1'b0, 1'b1, 1'b1, 32'h8000_0180, 64'd0}
  };

  logic clk = 0, rst_n = 0;
  logic epc_we = 0, cause_we = 0, cause_sel = 0, vec_mode = 0;
  logic [31:0] pc_in = '0;
  logic [31:0] epc_out, cause_out, handler_addr;
  int checks = 0, errors = 0;
  logic [31:0] m_epc = '0, m_cause = '0;

  always #(PERIOD/2) clk = ~clk;

  exc_capture u_exc_capture (
    .clk(clk), .rst_n(rst_n), .epc_we(epc_we), .cause_we(cause_we),
    .cause_sel(cause_sel), .pc_in(pc_in), .vec_mode(vec_mode),
    .epc_out(epc_out), .cause_out(cause_out), .handler_addr(handler_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(PERIOD*5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD*2 + 1);
    check("R1 epc in reset", epc_out, 32'h0);
    check("R1 cause in reset", cause_out, 32'h0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 epc after release", epc_out, 32'h0);
    check("R1 cause after release", cause_out, 32'h0);

    for (int i = 0; i < NROW; i++) begin
      pc_in     = ROWS[i][131:100];
      cause_sel = ROWS[i][99];
      vec_mode  = ROWS[i][98];
      epc_we    = ROWS[i][97];
      cause_we  = ROWS[i][96];
      #1;
      check(vec_mode ? "R7 vectored handler" : "R6 common handler",
            handler_addr, ROWS[i][95:64]);
      @(posedge clk);
      if (epc_we)   m_epc   = pc_in - 32'd4;
      if (cause_we) m_cause = {27'd0, 4'd0, cause_sel} << 2;
      @(negedge clk);
      check(epc_we ? "R2 epc load" : (cause_we ? "R3/R8 epc hold" : "R3 epc hold"),
            epc_out, m_epc);
      check(cause_we ? "R4 cause load" : (epc_we ? "R5/R8 cause hold" : "R5 cause hold"),
            cause_out, m_cause);
    end

    // R6: common entry ignores cause_sel, R7: combinational switch without a clock edge
    epc_we = 0; cause_we = 0; vec_mode = 0; cause_sel = 1;
    #1 check("R6 common ignores cause", handler_addr, 32'h8000_0180);
    vec_mode = 1;
    #1 check("R7 same-cycle vector", handler_addr, 32'hC000_0020);
    cause_sel = 0;
    #1 check("R7 same-cycle vector", handler_addr, 32'hC000_0000);

    // R2: wraparound at pc 0
    pc_in = 32'h0; epc_we = 1;
    @(negedge clk);
    check("R2 epc wrap", epc_out, 32'hFFFF_FFFC);
    cause_we = 1; cause_sel = 1; epc_we = 0;
    @(negedge clk);
    check("R4 overflow code", cause_out, 32'h0000_0004);
    check("R8 epc untouched by cause write", epc_out, 32'hFFFF_FFFC);
    cause_we = 0;

    // R1: asynchronous reset mid-run
    #2 rst_n = 0;
    #1;
    check("R1 async clear epc", epc_out, 32'h0);
    check("R1 async clear cause", cause_out, 32'h0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 epc stays clear", epc_out, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule